// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This unit widens the 16-bit address of an 8-bit processor into an 18-bit physical address. The logical space is cut into four 16 KB windows. The two top address bits pick one of four map entries. That entry holds a 4-bit page number, which becomes the top of the physical address. The fourteen low address bits pass through untouched. The lookup is purely combinational, so the only delay added to a memory read is one small register-file read.

Software loads the map with I/O write cycles to a block of four I/O ports, one port per window. A second I/O port holds a set selector. The storage holds several complete maps, and one I/O write to the selector switches every window at once. Each map write and set change is captured while the I/O write strobe is active and takes effect on the first clock edge after the strobe ends. The page outputs therefore never move during the write cycle itself.

Top module: `page_mapper`

## Requirements
- R1: `phys_addr[13:0]` always equals `cpu_addr[13:0]` in the same cycle, with no clock edge involved.
- R2: `phys_addr[17:14]` equals the 4-bit entry of the active set indexed by `cpu_addr[15:14]`, with entry 0 at `cpu_addr[15:14]`=00 through entry 3 at 11, combinationally.
- R3: After reset the active set is 0. Set 0 holds pages 0,1,2,3 in entries 0,1,2,3, so the physical address equals the logical address. Every entry of sets 1 to 3 holds page 0.
- R4: An I/O write (`iorq_n`=0 and `wr_n`=0) to I/O address `MAP_PORT`+k, with k in 0..3 taken from `cpu_addr[1:0]` and the I/O address taken from `cpu_addr[7:0]`, loads entry k of the active set with `cpu_data[3:0]`. `cpu_data[7:4]` is ignored.
- R5: A map or set write leaves `phys_addr` unchanged for as long as the write strobe is held. It takes effect at the first rising clock edge at which the strobe is sampled inactive.
- R6: An I/O write to I/O address `SET_PORT` loads the active set with `cpu_data[1:0]`; `cpu_data[7:2]` is ignored. All later translations use that set's map.
- R7: `map_en` is 0 while the I/O write strobe is active, and 1 otherwise.
- R8: A write with `iorq_n`=1 (a memory write), or an I/O write to any address outside the map block and the set port, changes no entry and does not change the active set.
- R9: A map write changes only the one addressed entry of the active set. The other sets are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the bus and commit writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus (write data) |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| phys_addr | output | 18 | Physical address: page number over the low 14 bits |
| map_en | output | 1 | Map read enable, low during I/O write cycles |

## Verification
The assertions assume that each I/O write strobe stays active for at least one rising clock edge, so that its address and data are captured before the commit. They also assume that the bus is stable at that edge. The bench drives each strobe across two full clock periods and changes address, data and strobes only on falling edges. The check that the page is stable during a write assumes that the top address bits do not move while the strobe is held. The bench holds the I/O address constant for the whole write.

// File: rtl/page_mapper.sv
module page_mapper #(
  parameter int          PAGE_W   = 4,
  parameter int          SET_W    = 2,
  parameter bit          USE_SETS = 1'b1,
  parameter logic [7:0]  MAP_PORT = 8'h40,
  parameter logic [7:0]  SET_PORT = 8'h44
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            cpu_addr,
  input  logic [7:0]             cpu_data,
  input  logic                   iorq_n,
  input  logic                   wr_n,
  output logic [PAGE_W+13:0]     phys_addr,
  output logic                   map_en
);
  localparam int NSETS   = USE_SETS ? (1 << SET_W) : 1;
  localparam int ENTRIES = NSETS * 4;
  localparam int IDX_W   = SET_W + 2;

  logic              strobe, strobe_q;
  logic [7:0]        lat_port;
  logic [7:0]        lat_data;
  logic              lat_map_hit, lat_set_hit, commit;
  logic [SET_W-1:0]  set_sel;
  logic [PAGE_W-1:0] map_q [ENTRIES];
  logic [IDX_W-1:0]  rd_idx, wr_idx;

  assign strobe      = !iorq_n && !wr_n;
  assign map_en      = !strobe;
  assign commit      = strobe_q && !strobe;
  assign lat_map_hit = lat_port[7:2] == MAP_PORT[7:2];
  assign lat_set_hit = lat_port == SET_PORT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      lat_port <= '0;
      lat_data <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) begin
        lat_port <= cpu_addr[7:0];
        lat_data <= cpu_data;
      end
    end
  end

  generate
    if (USE_SETS) begin : g_sets
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     set_sel <= '0;
        else if (commit && lat_set_hit) set_sel <= lat_data[SET_W-1:0];
      end
    end else begin : g_single
      assign set_sel = '0;
    end
  endgenerate

  assign rd_idx = {set_sel, cpu_addr[15:14]};
  assign wr_idx = {set_sel, lat_port[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        map_q[i] <= (i < 4) ? PAGE_W'(i) : '0;
    end else if (commit && lat_map_hit) begin
      map_q[wr_idx] <= lat_data[PAGE_W-1:0];
    end
  end

  assign phys_addr = {map_q[rd_idx], cpu_addr[13:0]};

  // checking support: copy of the map one cycle back
  logic [PAGE_W-1:0] map_prev [ENTRIES];
  logic [ENTRIES-1:0] entry_chg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        map_prev[i] <= (i < 4) ? PAGE_W'(i) : '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        map_prev[i] <= map_q[i];
    end
  end
  always_comb
    for (int i = 0; i < ENTRIES; i++)
      entry_chg[i] = map_q[i] != map_prev[i];

  assert_one_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_chg));

  assert_map_hit_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|entry_chg) |-> $past(strobe_q && !strobe && lat_map_hit));

  assert_set_hit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(set_sel) |-> $past(strobe_q && !strobe && lat_set_hit));

  assert_hold_during_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe) && $stable(cpu_addr[15:14])) |-> $stable(phys_addr[PAGE_W+13:14]));

  assert_oe_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !wr_n) |-> (map_en == 1'b0));
endmodule

// File: tb/page_mapper_test.sv
module page_mapper_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_data = 0;
  logic        iorq_n = 1, wr_n = 1;
  logic [17:0] phys_addr;
  logic        map_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_mapper uut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
                   .iorq_n(iorq_n), .wr_n(wr_n), .phys_addr(phys_addr), .map_en(map_en));

  // {set, logical address, expected physical address}
  localparam logic [35:0] VEC [8] = '{
    {2'd0, 16'h0123, 18'h14123}, {2'd0, 16'h7FFF, 18'h33FFF},
    {2'd0, 16'h8000, 18'h04000}, {2'd0, 16'hC0A5, 18'h380A5},
    {2'd1, 16'h1234, 18'h09234}, {2'd1, 16'h4321, 18'h24321},
    {2'd1, 16'hBEEF, 18'h03EEF}, {2'd1, 16'hFFFF, 18'h03FFF}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = {8'h00, port}; cpu_data = d; iorq_n = 0; wr_n = 0;
    @(negedge clk); @(negedge clk);
    iorq_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [17:0] exp);
    @(negedge clk);
    cpu_addr = a;
    #1 check(req, phys_addr, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1;
    // R3: identity map in set 0, map_en high
    for (int w = 0; w < 4; w++)
      read_chk("R3", 16'(w * 16'h4000 + 16'h0155), 18'(w * 18'h4000 + 18'h0155));
    check("R7 idle", map_en, 1);
    io_write(8'h44, 8'h02);
    read_chk("R3 set2 zero", 16'hC001, 18'h00001);
    io_write(8'h44, 8'hFC);  // R6: upper bits ignored -> set 0
    read_chk("R6 set0", 16'h8002, 18'h08002);

    // program set 0 (R4: upper data nibble ignored)
    io_write(8'h40, 8'hA5); io_write(8'h41, 8'h0C);
    io_write(8'h42, 8'h31); io_write(8'h43, 8'h7E);
    io_write(8'h44, 8'hFD);  // set 1
    io_write(8'h40, 8'h02); io_write(8'h41, 8'hF9);

    for (int i = 0; i < 8; i++) begin
      io_write(8'h44, {6'd0, VEC[i][35:34]});
      read_chk("R2/R4/R6/R9 table", VEC[i][33:18], VEC[i][17:0]);
      check("R1 low bits", phys_addr[13:0], VEC[i][31:18]);
    end

    // R5 / R7: set 0, rewrite entry 0 from 5 to 6; no change while strobe held
    io_write(8'h44, 8'h00);
    @(negedge clk);
    cpu_addr = 16'h0040; cpu_data = 8'h06; iorq_n = 0; wr_n = 0;
    #1 check("R7 low in write", map_en, 0);
    @(negedge clk);
    check("R5 hold", phys_addr, 18'h14040);
    @(negedge clk);
    check("R5 hold late", phys_addr, 18'h14040);
    iorq_n = 1; wr_n = 1;
    #1 check("R5 not before edge", phys_addr, 18'h14040);
    @(negedge clk);
    check("R5 after edge", phys_addr, 18'h18040);

    // R8: memory write to a map-like address, and I/O write elsewhere
    @(negedge clk);
    cpu_addr = 16'h0041; cpu_data = 8'h0F; iorq_n = 1; wr_n = 0;
    @(negedge clk); @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    io_write(8'h48, 8'h0B);
    io_write(8'h45, 8'h03);
    read_chk("R8 entry1 kept", 16'h4000, 18'h30000);
    read_chk("R8 entry0 kept", 16'h0000, 18'h18000);
    io_write(8'h44, 8'h01);
    read_chk("R8 set1 kept", 16'h4000, 18'h24000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule